// File: doc/BRIEF.md
# Divider Configuration Loader

This block keeps the settings a clock synthesizer's dividers run from: a 9-bit feedback divider value, two 3-bit output divider codes (bank A and bank B) and a 2-bit test-select code. The settings come either from parallel pins, framed by an active-low parallel strobe, or from a three-wire serial port made of a serial clock, a data line and a serial load strobe. The dividers and the PLL sit outside this block. It presents the active values on its outputs and drives a test pin whose source depends on the test-select code.

The serial clock and both strobes are asynchronous to the block. They pass through a synchronizer into the system clock domain and their edges are found there, so every serial bit and every strobe edge has to last a few system clock periods. While the parallel strobe is low the outputs follow the pins. That state also holds after reset, so the dividers start from the pin values before anything has been loaded.

Top module: `divcfg_loader`

## Requirements
- R1: While the synchronized parallel strobe is low, including the state right after reset, `m_o`, `na_o` and `nb_o` follow `par_m_i`, `par_na_i` and `par_nb_i`.
- R2: A rising edge on `par_load_ni` captures the pin values. Later pin changes leave the outputs unchanged until the strobe falls again or a serial transfer happens.
- R3: A serial word is 17 bits and is sent first bit first: test bit 1, test bit 0, bank-B code bits 2..0, bank-A code bits 2..0, then feedback bits 8..0. Each bit is taken on a rising serial clock edge.
- R4: Serial shifting while the serial load strobe is low leaves the active outputs unchanged.
- R5: A rising edge on `ser_load_i` with the parallel strobe high copies the shift register into the active values. The falling edge of the strobe leaves them as they are.
- R6: While `ser_load_i` stays high in serial mode, each rising serial clock edge shifts the register and puts the shifted word straight onto the active values.
- R7: A serial transfer replaces values that a parallel strobe captured. A later fall of the parallel strobe returns the outputs to the pins.
- R8: `test_o` is low whenever the parallel strobe is low, whatever the test-select code.
- R9: With the parallel strobe high, test code 00 drives `test_o` low, 01 drives it from the shift register's outgoing bit (the oldest bit held), 10 from `fb_div_i`, and 11 from `bank_a_clk_i`.
- R10: Serial clock edges seen while the parallel strobe is low do not change the shift register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock; all inputs are sampled on it |
| rst_ni | input | 1 | Active-low asynchronous reset |
| par_load_ni | input | 1 | Parallel strobe, low = pins pass through, rising edge = capture |
| par_m_i | input | 9 | Parallel feedback divider value |
| par_na_i | input | 3 | Parallel bank-A output divider code |
| par_nb_i | input | 3 | Parallel bank-B output divider code |
| ser_clk_i | input | 1 | Serial shift clock |
| ser_data_i | input | 1 | Serial data |
| ser_load_i | input | 1 | Serial load strobe |
| fb_div_i | input | 1 | Feedback divider output, routed to the test pin |
| bank_a_clk_i | input | 1 | Bank-A output clock, routed to the test pin |
| m_o | output | 9 | Active feedback divider value |
| na_o | output | 3 | Active bank-A code |
| nb_o | output | 3 | Active bank-B code |
| test_o | output | 1 | Test output |

## Verification
The assertions check the cycle-level rules on every cycle: the parallel capture, the shift-register step and its hold in parallel mode, the copy on a serial load edge, the pass-through while the load strobe is high, outputs that stay stable while shifting, and a test pin held low in parallel mode. Only the bench scenarios can show the things that depend on a whole sequence. These are the 17-bit field order of complete words, that a serial transfer overrides a parallel capture, that a later parallel capture leaves the shift register's contents in place, and that each of the four test-select codes routes the right source.

// File: rtl/divcfg_pkg.sv
package divcfg_pkg;
  typedef enum logic [1:0] {
    TSEL_LOW   = 2'b00,
    TSEL_SHIFT = 2'b01,
    TSEL_FB    = 2'b10,
    TSEL_BANKA = 2'b11
  } tsel_e;
endpackage

// File: rtl/divcfg_sync.sv
module divcfg_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned W      = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0][STAGES-1:0] chain_q;

  for (genvar b = 0; b < W; b++) begin : g_bit
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[b] <= '0;
        else         chain_q[b] <= async_i[b];
      end
    end else begin : g_multi
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[b] <= '0;
        else         chain_q[b] <= {chain_q[b][STAGES-2:0], async_i[b]};
      end
    end
    assign sync_o[b] = chain_q[b][STAGES-1];
  end
endmodule

// File: rtl/divcfg_shreg.sv
module divcfg_shreg #(
  parameter int unsigned WW = 17
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          shift_i,
  input  logic          din_i,
  output logic [WW-1:0] q_o,
  output logic [WW-1:0] next_o
);
  logic [WW-1:0] q;

  assign next_o = {q[WW-2:0], din_i};
  assign q_o    = q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q <= '0;
    else if (shift_i) q <= next_o;
  end

  AST_SR_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_i |=> q_o[0] == $past(din_i)); // R3
  AST_SR_MOVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_i |=> q_o[WW-1:1] == $past(q_o[WW-2:0])); // R3
  AST_SR_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shift_i |=> $stable(q_o)); // R10
endmodule

// File: rtl/divcfg_tmux.sv
module divcfg_tmux
  import divcfg_pkg::*;
(
  input  tsel_e sel_i,
  input  logic  en_i,
  input  logic  sr_out_i,
  input  logic  fb_i,
  input  logic  banka_i,
  output logic  test_o
);
  always_comb begin
    test_o = 1'b0;
    if (en_i) begin
      unique case (sel_i)
        TSEL_LOW:   test_o = 1'b0;
        TSEL_SHIFT: test_o = sr_out_i;
        TSEL_FB:    test_o = fb_i;
        TSEL_BANKA: test_o = banka_i;
        default:    test_o = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/divcfg_loader.sv
module divcfg_loader
  import divcfg_pkg::*;
#(
  parameter int unsigned M_W         = 9,
  parameter int unsigned N_W         = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           par_load_ni,
  input  logic [M_W-1:0] par_m_i,
  input  logic [N_W-1:0] par_na_i,
  input  logic [N_W-1:0] par_nb_i,
  input  logic           ser_clk_i,
  input  logic           ser_data_i,
  input  logic           ser_load_i,
  input  logic           fb_div_i,
  input  logic           bank_a_clk_i,
  output logic [M_W-1:0] m_o,
  output logic [N_W-1:0] na_o,
  output logic [N_W-1:0] nb_o,
  output logic           test_o
);
  localparam int unsigned T_W    = 2;
  localparam int unsigned WORD_W = T_W + 2*N_W + M_W;
  localparam int unsigned NA_LO  = M_W;
  localparam int unsigned NB_LO  = M_W + N_W;
  localparam int unsigned T_LO   = M_W + 2*N_W;
  localparam int unsigned CTL_W  = 3;  // [0] parallel strobe, [1] serial clock, [2] serial load

  logic [CTL_W-1:0]  ctl_s, ctl_prev_q;
  logic              sdata_s;
  logic              pl_lvl, pl_rise, sclk_rise, sld_rise, sld_high, ser_act, shift_en;
  logic [WORD_W-1:0] sr_q, sr_next, held_q;

  divcfg_sync #(.STAGES(SYNC_STAGES), .W(CTL_W)) u_ctl_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i({ser_load_i, ser_clk_i, par_load_ni}),
    .sync_o (ctl_s)
  );

  divcfg_sync #(.STAGES(SYNC_STAGES), .W(1)) u_dat_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(ser_data_i),
    .sync_o (sdata_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctl_prev_q <= '0;
    else         ctl_prev_q <= ctl_s;
  end

  assign pl_lvl    = ctl_prev_q[0];
  assign pl_rise   = ctl_s[0] & ~ctl_prev_q[0];
  assign sclk_rise = ctl_s[1] & ~ctl_prev_q[1];
  assign sld_rise  = ctl_s[2] & ~ctl_prev_q[2];
  assign sld_high  = ctl_s[2];
  assign ser_act   = ctl_s[0] & pl_lvl;
  assign shift_en  = ser_act & sclk_rise;

  divcfg_shreg #(.WW(WORD_W)) u_shreg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .shift_i(shift_en),
    .din_i  (sdata_s),
    .q_o    (sr_q),
    .next_o (sr_next)
  );

  // parallel capture wins; serial pass-through before edge transfer
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      held_q <= '0;
    end else if (pl_rise) begin
      held_q[M_W-1:0]         <= par_m_i;
      held_q[NA_LO +: N_W]    <= par_na_i;
      held_q[NB_LO +: N_W]    <= par_nb_i;
    end else if (shift_en && sld_high) begin
      held_q <= sr_next;
    end else if (ser_act && sld_rise) begin
      held_q <= sr_q;
    end
  end

  assign m_o  = pl_lvl ? held_q[M_W-1:0]      : par_m_i;
  assign na_o = pl_lvl ? held_q[NA_LO +: N_W] : par_na_i;
  assign nb_o = pl_lvl ? held_q[NB_LO +: N_W] : par_nb_i;

  divcfg_tmux u_tmux (
    .sel_i   (tsel_e'(held_q[T_LO +: T_W])),
    .en_i    (pl_lvl),
    .sr_out_i(sr_q[WORD_W-1]),
    .fb_i    (fb_div_i),
    .banka_i (bank_a_clk_i),
    .test_o  (test_o)
  );

  AST_PAR_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pl_rise |=> (m_o == $past(par_m_i)) && (na_o == $past(par_na_i)) && (nb_o == $past(par_nb_i))); // R2
  AST_PAR_TEST_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pl_lvl |-> !test_o); // R8
  AST_SHIFT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_en && !sld_high && !sld_rise) |=> $stable({m_o, na_o, nb_o})); // R4
  AST_LOAD_XFER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ser_act && sld_rise && !shift_en) |=>
      (m_o == $past(sr_q[M_W-1:0])) && (na_o == $past(sr_q[NA_LO +: N_W]))); // R5
  AST_PASS_THRU: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_en && sld_high) |=> (m_o == $past(sr_next[M_W-1:0])) && (nb_o == $past(sr_next[NB_LO +: N_W]))); // R6
  AST_CODE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pl_lvl && held_q[T_LO +: T_W] == 2'b00) |-> !test_o); // R9
endmodule

// File: tb/sim_divcfg_loader.sv
module sim_divcfg_loader;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       pload_n = 1'b0;
  logic [8:0] pm = '0;
  logic [2:0] pna = '0, pnb = '0;
  logic       sclk = 1'b0, sdata = 1'b0, sload = 1'b0;
  logic       fb = 1'b0, banka = 1'b0;
  logic [8:0] m_o;
  logic [2:0] na_o, nb_o;
  logic       test_o;

  typedef struct {
    logic [8:0] m;
    logic [2:0] na;
    logic [2:0] nb;
    logic       t;
    string      req;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0, errors = 0;
  bit   done = 1'b0;
  logic [16:0] sr_m = '0;

  always #2 clk = ~clk;

  divcfg_loader u0 (
    .clk_i(clk), .rst_ni(rst_ni), .par_load_ni(pload_n),
    .par_m_i(pm), .par_na_i(pna), .par_nb_i(pnb),
    .ser_clk_i(sclk), .ser_data_i(sdata), .ser_load_i(sload),
    .fb_div_i(fb), .bank_a_clk_i(banka),
    .m_o(m_o), .na_o(na_o), .nb_o(nb_o), .test_o(test_o)
  );

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_out(input logic [8:0] m, input logic [2:0] na, input logic [2:0] nb,
                            input logic t, input string req);
    exp_t e;
    e.m = m; e.na = na; e.nb = nb; e.t = t; e.req = req;
    exp_q.push_back(e);
    wait (exp_q.size() == 0);
  endtask

  task automatic expect_word(input logic [16:0] w, input logic t, input string req);
    expect_out(w[8:0], w[11:9], w[14:12], t, req);
  endtask

  task automatic shift_bit(input logic b);
    sdata = b;
    idle(4);
    sclk = 1'b1;
    idle(5);
    sclk = 1'b0;
    idle(5);
    if (pload_n) sr_m = {sr_m[15:0], b};
  endtask

  task automatic shift_word(input logic [16:0] w);
    for (int i = 16; i >= 0; i--) shift_bit(w[i]);
  endtask

  task automatic set_sload(input logic v);
    sload = v;
    idle(6);
  endtask

  // monitor: pops expected items once the design has settled
  initial begin
    exp_t cur;
    forever begin
      wait (exp_q.size() != 0);
      idle(6);
      cur = exp_q[0];
      checks++;
      if (m_o !== cur.m || na_o !== cur.na || nb_o !== cur.nb || test_o !== cur.t) begin
        errors++;
        $display("FAIL %s: got m=%h na=%0d nb=%0d test=%b, expected m=%h na=%0d nb=%0d test=%b",
                 cur.req, m_o, na_o, nb_o, test_o, cur.m, cur.na, cur.nb, cur.t);
      end
      void'(exp_q.pop_front());
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [16:0] wa, wb, wc, wd, we, wf, tmp;
    wa = {2'b00, 3'd2, 3'd4, 9'h123};
    wb = {2'b10, 3'd7, 3'd1, 9'h0F0};
    wc = {2'b11, 3'd3, 3'd5, 9'h04C};
    wd = {2'b01, 3'd6, 3'd0, 9'h1E1};
    we = {2'b00, 3'd1, 3'd7, 9'h0AB};
    wf = {2'b11, 3'd4, 3'd2, 9'h16D};

    pm = 9'h155; pna = 3'd3; pnb = 3'd5;
    idle(3);
    rst_ni = 1'b1;
    expect_out(9'h155, 3'd3, 3'd5, 1'b0, "R1 reset state follows pins");
    pm = 9'h0AA; pna = 3'd6; pnb = 3'd1;
    expect_out(9'h0AA, 3'd6, 3'd1, 1'b0, "R1 pins pass through");
    fb = 1'b1; banka = 1'b1;
    expect_out(9'h0AA, 3'd6, 3'd1, 1'b0, "R8 test low in parallel mode");
    fb = 1'b0; banka = 1'b0;

    pload_n = 1'b1;
    expect_out(9'h0AA, 3'd6, 3'd1, 1'b0, "R2 capture on strobe rise");
    pm = 9'h1FF;
    expect_out(9'h0AA, 3'd6, 3'd1, 1'b0, "R2 later pin change ignored");

    shift_word(wa);
    expect_out(9'h0AA, 3'd6, 3'd1, 1'b0, "R4 shifting leaves outputs");
    set_sload(1'b1);
    expect_word(wa, 1'b0, "R3 R5 word transferred on load rise");
    set_sload(1'b0);
    expect_word(wa, 1'b0, "R5 load fall keeps values");

    set_sload(1'b1);
    shift_bit(wb[16]);
    tmp = {wa[15:0], wb[16]};
    expect_word(tmp, 1'b0, "R6 first pass-through bit");
    for (int i = 15; i >= 0; i--) shift_bit(wb[i]);
    expect_word(wb, 1'b0, "R6 pass-through full word");
    set_sload(1'b0);
    fb = 1'b1;
    expect_word(wb, 1'b1, "R9 code 10 selects feedback high");
    fb = 1'b0;
    expect_word(wb, 1'b0, "R9 code 10 selects feedback low");

    shift_word(wc);
    set_sload(1'b1);
    set_sload(1'b0);
    banka = 1'b1;
    expect_word(wc, 1'b1, "R9 code 11 selects bank A high");
    banka = 1'b0;
    expect_word(wc, 1'b0, "R9 code 11 selects bank A low");

    shift_word(wd);
    set_sload(1'b1);
    set_sload(1'b0);
    expect_word(wd, wd[16], "R9 code 01 shift output bit");
    shift_bit(1'b0);
    expect_word(wd, wd[15], "R9 R4 code 01 follows shifted bit");

    shift_word(we);
    set_sload(1'b1);
    set_sload(1'b0);
    fb = 1'b1; banka = 1'b1;
    expect_word(we, 1'b0, "R9 code 00 drives low");

    shift_word(wf);
    set_sload(1'b1);
    set_sload(1'b0);
    expect_word(wf, 1'b1, "R3 word with code 11");
    pload_n = 1'b0;
    expect_out(9'h1FF, 3'd6, 3'd1, 1'b0, "R7 R8 strobe fall returns to pins");

    shift_bit(1'b1);
    shift_bit(1'b0);
    shift_bit(1'b1);
    pm = 9'h011; pna = 3'd2; pnb = 3'd3;
    pload_n = 1'b1;
    expect_out(9'h011, 3'd2, 3'd3, 1'b1, "R2 capture keeps test code");
    set_sload(1'b1);
    expect_word(sr_m, 1'b1, "R10 R7 shift reg untouched in parallel, serial overrides");
    set_sload(1'b0);
    banka = 1'b0; fb = 1'b0;
    expect_word(sr_m, 1'b0, "R9 bank A low after restore");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule